// File: doc/BRIEF.md
# Fault-Injected Switching Lattice Evaluator

The block evaluates a square lattice of four-terminal switches. Every site is tied to one of the input literals through a programmable selection field, and a site conducts when its literal is 1. After a run is started, the block spreads reachability through conducting sites, one orthogonal step per clock. It spreads from the top edge to decide whether a top-to-bottom path exists, and from the left edge to decide whether a left-to-right path exists. Sites that touch only at a corner never pass connectivity to each other.

Independent transition faults can be injected at random. For each trial a seeded pseudo-random generator gives every site its own byte. When that byte is below an 8-bit threshold, the site takes the inverse of its fault-free state. A run repeats this for a programmed number of trials and counts the trials that found a top-to-bottom path. The ratio of that count to the trial count estimates the path probability at the chosen fault rate. A threshold of zero gives plain deterministic evaluation.

Top module: `lattice_eval`

## Requirements
- R1: Site k (row k/N, column k%N, row 0 at the top, column 0 at the left) reads literal index `site_map[k*SELW +: SELW]` and conducts exactly when that literal is 1. An index at or beyond NUM_LIT makes the site non-conducting.
- R2: `f_top` is 1 after a trial exactly when a chain of conducting sites, each step between orthogonal neighbours, links some site of row 0 to some site of row N-1.
- R3: `g_left` is 1 after a trial exactly when such a chain links column 0 to column N-1.
- R4: Two conducting sites that share only a corner are not connected. A diagonal line of conducting sites gives `f_top` = 0 and `g_left` = 0.
- R5: With `fault_thr` = 0 no site is ever inverted. Every trial of a run then gives the same result, and `hit_cnt` equals `trial_cnt` times `f_top`.
- R6: With a nonzero `fault_thr`, a site is inverted in a trial when its pseudo-random byte is below `fault_thr`. At 255 an all-off lattice yields a top-to-bottom path in nearly every trial. At 128 an all-on lattice yields a mix of path and no-path trials.
- R7: A pulse on `start` while idle clears both counters and `done`, then runs `trial_target` trials. At the end, `trial_cnt` equals `trial_target`, `hit_cnt` counts the trials with a top-to-bottom path, `done` is 1 and `busy` is 0. A target of 0 finishes at once with zero trials.
- R8: `seed_load` while idle sets the generator state to `seed`, and a zero seed is replaced by a nonzero constant. The same seed and the same settings give the same `hit_cnt`.
- R9: After reset `busy`, `done`, `f_top`, `g_left`, `trial_cnt` and `hit_cnt` are all 0.
- R10: A trial takes one sampling cycle plus at most N*N spreading cycles. Spreading stops early once neither reached set changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run of trials (used while idle) |
| seed_load | input | 1 | Load the generator seed (used while idle) |
| seed | input | 32 | Generator seed value |
| site_map | input | N*N*SELW | Literal index for every site |
| lits | input | NUM_LIT | Literal values, sampled at the start of each trial |
| fault_thr | input | 8 | Inversion threshold; 0 disables injection |
| trial_target | input | CNT_W | Number of trials in a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |
| f_top | output | 1 | Top-to-bottom path found in the latest trial |
| g_left | output | 1 | Left-to-right path found in the latest trial |
| trial_cnt | output | CNT_W | Trials completed in this run |
| hit_cnt | output | CNT_W | Trials of this run with a top-to-bottom path |

## Verification
On every cycle the assertions check these properties:
- A zero threshold produces no inversions.
- The generator state is never zero.
- Reached sets never hold a non-conducting site and never shrink while spreading.
- The step counter stays within its cap.
- The success count never passes the trial count, and the trial count never passes the target.
- `done` never overlaps `busy`.

Whether a given lattice pattern really has a path can only be shown by the bench's scenarios, since it compares against hand-derived results. The same holds for the fault rate having the intended statistical effect and for a reloaded seed reproducing the same count.

// File: rtl/lattice_pkg.sv
package lattice_pkg;

    localparam int          RNG_W       = 32;
    localparam logic [31:0] RNG_POLY    = 32'hB4BC_D35C;
    localparam logic [31:0] RNG_NONZERO = 32'h0000_0001;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_FLOOD
    } phase_e;

    // Advance a right-shifting Galois generator by eight steps.
    function automatic logic [RNG_W-1:0] rng_step8(input logic [RNG_W-1:0] s);
        logic [RNG_W-1:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = t[0] ? ((t >> 1) ^ RNG_POLY) : (t >> 1);
        end
        return t;
    endfunction

endpackage

// File: rtl/lat_sitemap.sv
module lat_sitemap #(
    parameter int N       = 4,
    parameter int NUM_LIT = 16,
    parameter int SELW    = 4
) (
    input  logic [N*N*SELW-1:0] site_map,
    input  logic [NUM_LIT-1:0]  lits,
    output logic [N*N-1:0]      base_on
);
    localparam int NS = N * N;

    for (genvar k = 0; k < NS; k++) begin : g_site
        logic [SELW-1:0] idx;
        assign idx = site_map[k*SELW +: SELW];
        if (NUM_LIT == (1 << SELW)) begin : g_full
            assign base_on[k] = lits[idx];
        end else begin : g_part
            assign base_on[k] = (int'(idx) < NUM_LIT) ? lits[idx] : 1'b0;
        end
    end

endmodule

// File: rtl/lat_rng.sv
module lat_rng
    import lattice_pkg::*;
#(
    parameter int NSITE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RNG_W-1:0] seed,
    input  logic             adv,
    input  logic [7:0]       thr,
    output logic [NSITE-1:0] flip
);
    logic [RNG_W-1:0] state_d, state_q;
    logic [RNG_W-1:0] chain [0:NSITE];

    assign chain[0] = state_q;

    for (genvar k = 0; k < NSITE; k++) begin : g_byte
        assign chain[k+1] = rng_step8(chain[k]);
        assign flip[k]    = (chain[k+1][7:0] < thr);
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (seed == '0) ? RNG_NONZERO : seed;
        end else if (adv) begin
            state_d = chain[NSITE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RNG_NONZERO;
        else        state_q <= state_d;
    end

    // R5
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == 8'd0) |-> (flip == '0));

    // R8
    rng_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/lat_flood.sv
module lat_flood #(
    parameter int N      = 4,
    parameter bit ACROSS = 1'b0
) (
    input  logic [N*N-1:0] on,
    input  logic [N*N-1:0] reach,
    output logic [N*N-1:0] src,
    output logic [N*N-1:0] nxt,
    output logic           hit_far
);
    logic [N*N-1:0] far_m;

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam int K = r * N + c;
            logic up, dn, lf, rt;
            if (r > 0)     begin : g_up assign up = reach[K-N]; end
            else           begin : g_nu assign up = 1'b0;       end
            if (r < N - 1) begin : g_dn assign dn = reach[K+N]; end
            else           begin : g_nd assign dn = 1'b0;       end
            if (c > 0)     begin : g_lf assign lf = reach[K-1]; end
            else           begin : g_nl assign lf = 1'b0;       end
            if (c < N - 1) begin : g_rt assign rt = reach[K+1]; end
            else           begin : g_nr assign rt = 1'b0;       end

            assign nxt[K] = on[K] & (reach[K] | up | dn | lf | rt);

            if (ACROSS) begin : g_lr
                assign src[K]   = (c == 0) ? on[K] : 1'b0;
                assign far_m[K] = (c == N - 1);
            end else begin : g_tb
                assign src[K]   = (r == 0) ? on[K] : 1'b0;
                assign far_m[K] = (r == N - 1);
            end
        end
    end

    assign hit_far = |(nxt & far_m);

endmodule

// File: rtl/lattice_eval.sv
module lattice_eval
    import lattice_pkg::*;
#(
    parameter int N       = 4,
    parameter int NUM_LIT = 16,
    parameter int SELW    = (NUM_LIT > 1) ? $clog2(NUM_LIT) : 1,
    parameter int CNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 seed_load,
    input  logic [31:0]          seed,
    input  logic [N*N*SELW-1:0]  site_map,
    input  logic [NUM_LIT-1:0]   lits,
    input  logic [7:0]           fault_thr,
    input  logic [CNT_W-1:0]     trial_target,
    output logic                 busy,
    output logic                 done,
    output logic                 f_top,
    output logic                 g_left,
    output logic [CNT_W-1:0]     trial_cnt,
    output logic [CNT_W-1:0]     hit_cnt
);
    localparam int             NS   = N * N;
    localparam int             IT_W = $clog2(NS) + 1;
    localparam logic [IT_W-1:0] CAP = IT_W'(NS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [NS-1:0]   on;
        logic [NS-1:0]   rt;
        logic [NS-1:0]   rl;
        logic [IT_W-1:0] iter;
        logic [CNT_W-1:0] trials;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] target;
        logic            f;
        logic            g;
        logic            done;
    } st_t;

    st_t q, n;

    logic [NS-1:0] base_on, flip, live_on, on_use;
    logic [NS-1:0] src_t, src_l, nxt_t, nxt_l;
    logic          far_t, far_l;
    logic [CNT_W-1:0] tr_inc;

    lat_sitemap #(.N(N), .NUM_LIT(NUM_LIT), .SELW(SELW)) u_map (
        .site_map (site_map),
        .lits     (lits),
        .base_on  (base_on)
    );

    lat_rng #(.NSITE(NS)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load && (q.phase == PH_IDLE)),
        .seed  (seed),
        .adv   (q.phase == PH_LOAD),
        .thr   (fault_thr),
        .flip  (flip)
    );

    assign live_on = base_on ^ flip;
    assign on_use  = (q.phase == PH_LOAD) ? live_on : q.on;

    lat_flood #(.N(N), .ACROSS(1'b0)) u_down (
        .on (on_use), .reach (q.rt), .src (src_t), .nxt (nxt_t), .hit_far (far_t)
    );

    lat_flood #(.N(N), .ACROSS(1'b1)) u_across (
        .on (on_use), .reach (q.rl), .src (src_l), .nxt (nxt_l), .hit_far (far_l)
    );

    assign tr_inc = q.trials + CNT_W'(1);

    always_comb begin
        n = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    n.trials = '0;
                    n.hits   = '0;
                    n.target = trial_target;
                    n.done   = (trial_target == '0);
                    if (trial_target != '0) n.phase = PH_LOAD;
                end
            end
            PH_LOAD: begin
                n.on    = live_on;
                n.rt    = src_t;
                n.rl    = src_l;
                n.iter  = '0;
                n.phase = PH_FLOOD;
            end
            PH_FLOOD: begin
                if (((nxt_t == q.rt) && (nxt_l == q.rl)) || (q.iter == CAP)) begin
                    n.f      = far_t;
                    n.g      = far_l;
                    n.trials = tr_inc;
                    n.hits   = q.hits + CNT_W'(far_t);
                    if (tr_inc == q.target) begin
                        n.phase = PH_IDLE;
                        n.done  = 1'b1;
                    end else begin
                        n.phase = PH_LOAD;
                    end
                end else begin
                    n.rt   = nxt_t;
                    n.rl   = nxt_l;
                    n.iter = q.iter + IT_W'(1);
                end
            end
            default: n.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, default: '0};
        else        q <= n;
    end

    assign busy      = (q.phase != PH_IDLE);
    assign done      = q.done;
    assign f_top     = q.f;
    assign g_left    = q.g;
    assign trial_cnt = q.trials;
    assign hit_cnt   = q.hits;

    // R2
    reach_in_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_FLOOD) |-> (((q.rt | q.rl) & ~q.on) == '0));

    // R10
    reach_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_FLOOD) && ($past(q.phase) == PH_FLOOD))
            |-> (((q.rt & $past(q.rt)) == $past(q.rt)) && ((q.rl & $past(q.rl)) == $past(q.rl))));

    // R10
    iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.iter <= CAP);

    // R7
    hits_le_trials_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.hits <= q.trials);

    // R7
    trials_le_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.trials <= q.target);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/tb_lattice_eval.sv
`timescale 1ns/1ps
module tb_lattice_eval;
    localparam int N = 4;
    localparam int NS = N * N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed = '0;
    logic [NS*4-1:0] site_map = '0;
    logic [15:0] lits = '0;
    logic [7:0]  fault_thr = '0;
    logic [15:0] trial_target = '0;
    logic        busy, done, f_top, g_left;
    logic [15:0] trial_cnt, hit_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit wd_hit = 1'b0;

    always #2 clk = ~clk;

    lattice_eval dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load), .seed(seed),
        .site_map(site_map), .lits(lits), .fault_thr(fault_thr), .trial_target(trial_target),
        .busy(busy), .done(done), .f_top(f_top), .g_left(g_left),
        .trial_cnt(trial_cnt), .hit_cnt(hit_cnt)
    );

    // {lits, expected f_top, expected g_left}; bit r*4+c is row r, column c
    localparam int NV = 9;
    localparam logic [17:0] VEC [0:NV-1] = '{
        {16'h0000, 1'b0, 1'b0},
        {16'hFFFF, 1'b1, 1'b1},
        {16'h1111, 1'b1, 1'b0},
        {16'h0F00, 1'b0, 1'b1},
        {16'h8421, 1'b0, 1'b0},
        {16'h2231, 1'b1, 1'b0},
        {16'h1F8F, 1'b1, 1'b1},
        {16'hC222, 1'b0, 1'b0},
        {16'hF888, 1'b1, 1'b1}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NS*4-1:0] make_map(input int kind);
        logic [NS*4-1:0] m;
        m = '0;
        for (int k = 0; k < NS; k++) begin
            case (kind)
                1:       m[k*4 +: 4] = 4'(k % N);
                2:       m[k*4 +: 4] = 4'(k / N);
                default: m[k*4 +: 4] = 4'(k);
            endcase
        end
        return m;
    endfunction

    task automatic run_trials(input logic [15:0] tgt, output int busy_cycles);
        trial_target = tgt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        busy_cycles = 0;
        while (!done) begin
            if (busy) busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk);
        seed = s;
        seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    initial begin
        int bc;
        int h1, h2;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(done == 1'b0, "R9 done", done, 0);
        chk(f_top == 1'b0, "R9 f_top", f_top, 0);
        chk(g_left == 1'b0, "R9 g_left", g_left, 0);
        chk(trial_cnt == 0, "R9 trial_cnt", trial_cnt, 0);
        chk(hit_cnt == 0, "R9 hit_cnt", hit_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: deterministic vectors with identity map
        site_map = make_map(0);
        fault_thr = 8'd0;
        for (int i = 0; i < NV; i++) begin
            lits = VEC[i][17:2];
            run_trials(16'd1, bc);
            chk(f_top == VEC[i][1], $sformatf("R2 f_top vec %0d", i), f_top, VEC[i][1]);
            chk(g_left == VEC[i][0], $sformatf("R3 g_left vec %0d", i), g_left, VEC[i][0]);
        end

        // R10 serpentine finishes within N*N+1 busy cycles
        lits = 16'h1F8F;
        run_trials(16'd1, bc);
        chk(bc <= NS + 1, "R10 trial length", bc, NS + 1);
        chk(f_top == 1'b1, "R10 serpentine f_top", f_top, 1);

        // R1 shared literals: column map and row map
        site_map = make_map(1);
        lits = 16'h0001;
        run_trials(16'd1, bc);
        chk(f_top == 1'b1, "R1 column literal f_top", f_top, 1);
        chk(g_left == 1'b0, "R1 column literal g_left", g_left, 0);
        lits = 16'hFFF0;
        run_trials(16'd1, bc);
        chk(f_top == 1'b0, "R1 unmapped literals f_top", f_top, 0);
        site_map = make_map(2);
        lits = 16'h0004;
        run_trials(16'd1, bc);
        chk(f_top == 1'b0, "R1 row literal f_top", f_top, 0);
        chk(g_left == 1'b1, "R1 row literal g_left", g_left, 1);

        // R5 R7 zero threshold, multi-trial
        site_map = make_map(0);
        lits = 16'h2231;
        run_trials(16'd50, bc);
        chk(trial_cnt == 50, "R7 trial_cnt", trial_cnt, 50);
        chk(hit_cnt == 50, "R5 hit_cnt path", hit_cnt, 50);
        chk(busy == 1'b0 && done == 1'b1, "R7 done/busy", {busy, done}, 1);
        lits = 16'h8421;
        run_trials(16'd20, bc);
        chk(hit_cnt == 0, "R5 R4 hit_cnt diagonal", hit_cnt, 0);
        chk(trial_cnt == 20, "R7 trial_cnt 20", trial_cnt, 20);

        // R7 zero target
        run_trials(16'd0, bc);
        chk(done == 1'b1 && trial_cnt == 0, "R7 zero target", trial_cnt, 0);

        // R6 R8 random injection
        lits = 16'hFFFF;
        fault_thr = 8'd128;
        load_seed(32'h1234_ABCD);
        run_trials(16'd200, bc);
        h1 = hit_cnt;
        chk(h1 > 0 && h1 < 200, "R6 mixed outcomes at 128", h1, 100);
        load_seed(32'h1234_ABCD);
        run_trials(16'd200, bc);
        h2 = hit_cnt;
        chk(h2 == h1, "R8 repeatable seed", h2, h1);
        load_seed(32'h0);
        run_trials(16'd100, bc);
        chk(hit_cnt > 0 && hit_cnt < 100, "R8 zero seed replaced", hit_cnt, 50);

        lits = 16'h0000;
        fault_thr = 8'd255;
        run_trials(16'd100, bc);
        chk(hit_cnt >= 90, "R6 threshold 255 turns sites on", hit_cnt, 100);
        chk(trial_cnt == 100, "R7 trial_cnt 100", trial_cnt, 100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule